// File: doc/BRIEF.md
# CPU Clock Rate Transition Sequencer

This block is a hardware state machine that steps the CPU clock domain through a rate change while the PLL feeding that domain is retuned. It acts as a master on the register bus of the clock control unit. It writes the mux select and divider registers and polls their status registers. It never programs the PLL itself.

A pre-change request carries the old rate, the new rate and the rate of the alternate source. The sequencer scans a parameter table for an entry whose rate equals the new rate.

- If no entry matches, it stops without any register write and reports an error.
- If a matching entry is found and the alternate source could drive the core faster than allowed, it computes a protective divider with an iterative divider. It writes that divider first, so the core clock never runs above the lower of the old and new rates.
- It then moves the domain onto the alternate source and loads the target dividers.
- Finally it raises a ready output. The PLL can then be retuned.

A later post-change request moves the domain back to the PLL and clears the core ratio.

Each status poll gives up after a set number of cycles. A poll that gives up marks an error, and the sequence still goes on.

Top module: `dvfs_clk_seq`

## Requirements
- R1: After reset, busy, done, err, warn and pll_ready are 0, and the bus shows no read or write while busy is 0.
- R2: The new rate is compared against the table one entry at a time. An entry whose rate is 0 never matches and ends the scan. Reaching that entry, or passing the last entry, with no match sets err and pulses done. In that case no bus write occurs and pll_ready stays 0.
- R3: A protective divider is applied only when the alternate rate exceeds the old rate, or when the old rate exceeds the new rate. Otherwise the first pre-change write is the mux select, and divider 0 is loaded with the table value alone.
- R4: The protective value is ceil(alternate / min(old, new)) − 1. It is written by read-modify-write to divider 0 (address 2), in the core ratio field bits [2:0]. All other bits are kept. When dbg_div_en is 1, the debug field bits [18:16] of that write are forced to 7.
- R5: When ceil(alternate / min(old, new)) − 1 is 8 or more, warn is set. The ratio field then takes the low three bits of the value.
- R6: The pre-change write order is fixed, and each write is followed by a poll of its status register:
  - the protective divider, if needed, polled until the masked bits of address 3 are 0;
  - mux select address 0 with bit 16 set by read-modify-write, polled until address 1 bits [18:16] equal 2;
  - divider 0 equal to the table value OR the protective value, polled until address 3 is 0;
  - divider 1 at address 4 when has_div1 is 1, polled until address 5 is 0.

  After the last poll, pll_ready rises together with done.
- R7: When bit 20 of the mux select register reads 1 at the start of the switch, divider 1 is written with its current bits [6:4] and [2:0] and zeros elsewhere. Otherwise it is written with the table value.
- R8: Post-change order is:
  - clear bit 16 of address 0 by read-modify-write, then poll until address 1 bits [18:16] equal 1;
  - read-modify-write divider 0 with bits [2:0] set to 0. When dbg_div_en is 1, bits [18:16] take the table entry matched by the last pre-change.

  pll_ready falls when the post-change request is accepted.
- R9: A poll whose condition is not met within TIMEOUT_CYC cycles sets err and moves on to the next step.
- R10: busy is high from the accepted request until the end of its sequence. done is a single-cycle pulse as busy falls. err and warn hold until the next accepted request clears them.
- R11: pre_req is accepted only when idle with pll_ready 0. post_req is accepted only when idle with pll_ready 1. Any other request leaves busy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_req | input | 1 | Start the pre-change sequence |
| post_req | input | 1 | Start the post-change sequence |
| old_rate | input | RATE_W | Current PLL rate |
| new_rate | input | RATE_W | Target PLL rate |
| alt_rate | input | RATE_W | Alternate source rate |
| dbg_div_en | input | 1 | Also protect and restore the debug divider field |
| has_div1 | input | 1 | Divider 1 register is present |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_addr | output | 4 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid in the cycle of bus_rd |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Sticky: no table match or a poll timeout |
| warn | output | 1 | Sticky: protective divider out of range |
| pll_ready | output | 1 | Domain is on the alternate source; the PLL may be retuned |

## Verification
The assertions assume that the register bus answers a read in the same cycle, combinationally, with no wait states. They also assume that requests and rates are steady while they are sampled at the accepting edge, and that the old rate is never 0.

The bench drives each request as a one-cycle pulse between clock edges. It holds the rates steady for the whole sequence, and it chooses old rates that are nonzero. Its register model answers every read at once. It keeps each status register unsettled for a few cycles after a write, and on one test it holds a status register unsettled indefinitely.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 32;

  // register addresses decoded by the clock control unit
  localparam logic [REG_AW-1:0] RA_SEL    = 4'h0;
  localparam logic [REG_AW-1:0] RA_SELST  = 4'h1;
  localparam logic [REG_AW-1:0] RA_DIV0   = 4'h2;
  localparam logic [REG_AW-1:0] RA_DIV0ST = 4'h3;
  localparam logic [REG_AW-1:0] RA_DIV1   = 4'h4;
  localparam logic [REG_AW-1:0] RA_DIV1ST = 4'h5;

  localparam int SEL_ALT_BIT = 16;
  localparam int SEL_HPM_BIT = 20;
  localparam int SELST_LSB   = 16;

  localparam logic [REG_DW-1:0] RATIO_M   = 32'h0000_0007;
  localparam logic [REG_DW-1:0] DBG_M     = 32'h0007_0000;
  localparam logic [REG_DW-1:0] D1_KEEP_M = 32'h0000_0077;
  localparam logic [REG_DW-1:0] ALT_SEL_M = 32'h0001_0000;

  localparam logic [2:0] MUXST_PRI = 3'd1;
  localparam logic [2:0] MUXST_ALT = 3'd2;

  typedef enum logic [4:0] {
    S_IDLE, S_LOOK, S_DIV,
    S_SAFE_RD, S_SAFE_WR, S_SAFE_POLL,
    S_MUXA_RD, S_MUXA_WR, S_MUXA_POLL,
    S_D1_RD, S_D0_WR, S_D0_POLL, S_D1_WR, S_D1_POLL,
    S_MUXP_RD, S_MUXP_WR, S_MUXP_POLL,
    S_REST_RD, S_REST_WR, S_REST_POLL
  } seq_st_t;
endpackage

// File: rtl/clkseq_lookup.sv
module clkseq_lookup #(
  parameter int N_ENT  = 5,
  parameter int RATE_W = 16,
  parameter logic [N_ENT-1:0][RATE_W-1:0] TBL_RATE = '0,
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RATE_W-1:0] target,
  output logic              hit,
  output logic              miss,
  output logic [IW-1:0]     idx
);
  logic          act;
  logic [IW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      ptr  <= '0;
      hit  <= 1'b0;
      miss <= 1'b0;
      idx  <= '0;
    end else begin
      hit  <= 1'b0;
      miss <= 1'b0;
      if (start) begin
        act <= 1'b1;
        ptr <= '0;
      end else if (act) begin
        if (TBL_RATE[ptr] == '0) begin
          miss <= 1'b1;
          act  <= 1'b0;
        end else if (TBL_RATE[ptr] == target) begin
          hit <= 1'b1;
          idx <= ptr;
          act <= 1'b0;
        end else if (ptr == IW'(N_ENT - 1)) begin
          miss <= 1'b1;
          act  <= 1'b0;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clkseq_divu.sv
module clkseq_divu #(
  parameter int W = 17,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  logic [W:0]    rem;
  logic [W-1:0]  q;
  logic [CW-1:0] cnt;
  logic          act;
  logic [W:0]    rem_sh;
  logic          ge;

  always_comb begin
    rem_sh = {rem[W-1:0], q[W-1]};
    ge     = (rem_sh >= {1'b0, den});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      q    <= '0;
      cnt  <= '0;
      act  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= '0;
        q   <= num;
        cnt <= CW'(W);
        act <= 1'b1;
      end else if (act) begin
        rem <= ge ? (rem_sh - {1'b0, den}) : rem_sh;
        q   <= {q[W-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          act  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = q;
endmodule

// File: rtl/clkseq_wdog.sv
module clkseq_wdog #(
  parameter int LIMIT = 1000000,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  logic [TW-1:0] cnt;

  assign expired = en && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dvfs_clk_seq.sv
module dvfs_clk_seq
  import clkseq_pkg::*;
#(
  parameter int RATE_W      = 16,
  parameter int N_ENT       = 5,
  parameter int TIMEOUT_CYC = 1000000,
  parameter logic [N_ENT-1:0][RATE_W-1:0] TBL_RATE =
    {16'd0, 16'd500, 16'd800, 16'd1000, 16'd1200},
  parameter logic [N_ENT-1:0][REG_DW-1:0] TBL_DIV0 =
    {32'h0, 32'h0002_1100, 32'h0003_2100, 32'h0004_2100, 32'h0005_3100},
  parameter logic [N_ENT-1:0][REG_DW-1:0] TBL_DIV1 =
    {32'h0, 32'h23, 32'h33, 32'h43, 32'h53}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_req,
  input  logic              post_req,
  input  logic [RATE_W-1:0] old_rate,
  input  logic [RATE_W-1:0] new_rate,
  input  logic [RATE_W-1:0] alt_rate,
  input  logic              dbg_div_en,
  input  logic              has_div1,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [REG_AW-1:0] bus_addr,
  output logic [REG_DW-1:0] bus_wdata,
  input  logic [REG_DW-1:0] bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              warn,
  output logic              pll_ready
);
  localparam int QW = RATE_W + 1;
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  seq_st_t st;
  logic [RATE_W-1:0] o_q, n_q, a_q;
  logic [REG_DW-1:0] rd_q, sval_q, d1_q;
  logic              hpm_q, dbg_q, h1_q;

  logic              pre_acc, post_acc;
  logic              need;
  logic [RATE_W-1:0] lo_rate;
  logic [QW-1:0]     dv_num, dv_quo, q_m1;
  logic              dv_done, lk_hit, lk_miss;
  logic [IW-1:0]     lk_idx;
  logic [REG_DW-1:0] msk;
  logic              in_poll, cond, wd_exp, adv;

  assign pre_acc  = (st == S_IDLE) && pre_req && !pll_ready;
  assign post_acc = (st == S_IDLE) && !pre_req && post_req && pll_ready;
  assign need     = (a_q > o_q) || (o_q > n_q);
  assign lo_rate  = (o_q < n_q) ? o_q : n_q;
  assign dv_num   = {1'b0, a_q} + {1'b0, lo_rate} - QW'(1);
  assign q_m1     = dv_quo - QW'(1);
  assign msk      = RATIO_M | (dbg_q ? DBG_M : '0);
  assign busy     = (st != S_IDLE);

  clkseq_lookup #(.N_ENT(N_ENT), .RATE_W(RATE_W), .TBL_RATE(TBL_RATE)) u_look (
    .clk(clk), .rst(rst), .start(pre_acc), .target(n_q),
    .hit(lk_hit), .miss(lk_miss), .idx(lk_idx));

  clkseq_divu #(.W(QW)) u_div (
    .clk(clk), .rst(rst), .start((st == S_LOOK) && lk_hit && need),
    .num(dv_num), .den({1'b0, lo_rate}), .done(dv_done), .quo(dv_quo));

  clkseq_wdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
    .clk(clk), .rst(rst), .clr(!in_poll || cond), .en(in_poll),
    .expired(wd_exp));

  // poll conditions on the status read of the current state
  always_comb begin
    in_poll = 1'b1;
    cond    = 1'b0;
    case (st)
      S_SAFE_POLL, S_REST_POLL: cond = ((bus_rdata & msk) == '0);
      S_MUXA_POLL: cond = (bus_rdata[SELST_LSB +: 3] == MUXST_ALT);
      S_MUXP_POLL: cond = (bus_rdata[SELST_LSB +: 3] == MUXST_PRI);
      S_D0_POLL, S_D1_POLL: cond = (bus_rdata == '0);
      default: in_poll = 1'b0;
    endcase
    adv = cond || wd_exp;
  end

  // bus command decoded from state registers only
  always_comb begin
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (st)
      S_SAFE_RD:   begin bus_rd = 1'b1; bus_addr = RA_DIV0; end
      S_SAFE_WR:   begin bus_wr = 1'b1; bus_addr = RA_DIV0;
                         bus_wdata = (rd_q & ~msk) | (sval_q & msk); end
      S_SAFE_POLL: begin bus_rd = 1'b1; bus_addr = RA_DIV0ST; end
      S_MUXA_RD:   begin bus_rd = 1'b1; bus_addr = RA_SEL; end
      S_MUXA_WR:   begin bus_wr = 1'b1; bus_addr = RA_SEL;
                         bus_wdata = rd_q | ALT_SEL_M; end
      S_MUXA_POLL: begin bus_rd = 1'b1; bus_addr = RA_SELST; end
      S_D1_RD:     begin bus_rd = 1'b1; bus_addr = RA_DIV1; end
      S_D0_WR:     begin bus_wr = 1'b1; bus_addr = RA_DIV0;
                         bus_wdata = TBL_DIV0[lk_idx] | sval_q; end
      S_D0_POLL:   begin bus_rd = 1'b1; bus_addr = RA_DIV0ST; end
      S_D1_WR:     begin bus_wr = 1'b1; bus_addr = RA_DIV1; bus_wdata = d1_q; end
      S_D1_POLL:   begin bus_rd = 1'b1; bus_addr = RA_DIV1ST; end
      S_MUXP_RD:   begin bus_rd = 1'b1; bus_addr = RA_SEL; end
      S_MUXP_WR:   begin bus_wr = 1'b1; bus_addr = RA_SEL;
                         bus_wdata = rd_q & ~ALT_SEL_M; end
      S_MUXP_POLL: begin bus_rd = 1'b1; bus_addr = RA_SELST; end
      S_REST_RD:   begin bus_rd = 1'b1; bus_addr = RA_DIV0; end
      S_REST_WR:   begin bus_wr = 1'b1; bus_addr = RA_DIV0;
                         bus_wdata = (rd_q & ~msk) |
                                     (dbg_q ? (TBL_DIV0[lk_idx] & DBG_M) : '0); end
      S_REST_POLL: begin bus_rd = 1'b1; bus_addr = RA_DIV0ST; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      o_q       <= '0;
      n_q       <= '0;
      a_q       <= '0;
      rd_q      <= '0;
      sval_q    <= '0;
      d1_q      <= '0;
      hpm_q     <= 1'b0;
      dbg_q     <= 1'b0;
      h1_q      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      warn      <= 1'b0;
      pll_ready <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_poll && !cond && wd_exp) err <= 1'b1;
      case (st)
        S_IDLE: begin
          if (pre_acc) begin
            o_q   <= old_rate;
            n_q   <= new_rate;
            a_q   <= alt_rate;
            dbg_q <= dbg_div_en;
            h1_q  <= has_div1;
            err   <= 1'b0;
            warn  <= 1'b0;
            st    <= S_LOOK;
          end else if (post_acc) begin
            dbg_q     <= dbg_div_en;
            err       <= 1'b0;
            warn      <= 1'b0;
            pll_ready <= 1'b0;
            st        <= S_MUXP_RD;
          end
        end
        S_LOOK: begin
          if (lk_miss) begin
            err  <= 1'b1;
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (lk_hit) begin
            if (need) st <= S_DIV;
            else begin
              sval_q <= '0;
              st     <= S_MUXA_RD;
            end
          end
        end
        S_DIV: begin
          if (dv_done) begin
            sval_q <= (dbg_q ? DBG_M : '0) |
                      REG_DW'((dv_quo == '0) ? 3'd0 : q_m1[2:0]);
            if (dv_quo > QW'(8)) warn <= 1'b1;
            st <= S_SAFE_RD;
          end
        end
        S_SAFE_RD:   begin rd_q <= bus_rdata; st <= S_SAFE_WR; end
        S_SAFE_WR:   st <= S_SAFE_POLL;
        S_SAFE_POLL: if (adv) st <= S_MUXA_RD;
        S_MUXA_RD: begin
          rd_q  <= bus_rdata;
          hpm_q <= bus_rdata[SEL_HPM_BIT];
          st    <= S_MUXA_WR;
        end
        S_MUXA_WR: st <= S_MUXA_POLL;
        S_MUXA_POLL: begin
          if (adv) begin
            d1_q <= TBL_DIV1[lk_idx];
            st   <= (h1_q && hpm_q) ? S_D1_RD : S_D0_WR;
          end
        end
        S_D1_RD: begin d1_q <= bus_rdata & D1_KEEP_M; st <= S_D0_WR; end
        S_D0_WR: st <= S_D0_POLL;
        S_D0_POLL: begin
          if (adv) begin
            if (h1_q) st <= S_D1_WR;
            else begin
              done      <= 1'b1;
              pll_ready <= 1'b1;
              st        <= S_IDLE;
            end
          end
        end
        S_D1_WR: st <= S_D1_POLL;
        S_D1_POLL: begin
          if (adv) begin
            done      <= 1'b1;
            pll_ready <= 1'b1;
            st        <= S_IDLE;
          end
        end
        S_MUXP_RD:   begin rd_q <= bus_rdata; st <= S_MUXP_WR; end
        S_MUXP_WR:   st <= S_MUXP_POLL;
        S_MUXP_POLL: if (adv) st <= S_REST_RD;
        S_REST_RD:   begin rd_q <= bus_rdata; st <= S_REST_WR; end
        S_REST_WR:   st <= S_REST_POLL;
        S_REST_POLL: begin
          if (adv) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic err,
  input logic pll_ready,
  input logic bus_rd,
  input logic bus_wr
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  // R6
  rdy_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(pll_ready) |-> done);
  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !(bus_rd || bus_wr));
  // R11
  rdy_idle_chk: assert property (@(posedge clk) disable iff (rst) pll_ready |-> !busy);
  // R10
  err_clr_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !err);
  // R6
  bus_excl_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({bus_rd, bus_wr}));
endmodule

bind dvfs_clk_seq clkseq_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
  .pll_ready(pll_ready), .bus_rd(bus_rd), .bus_wr(bus_wr)
);

// File: tb/dvfs_clk_seq_tb.sv
module dvfs_clk_seq_tb;
  import clkseq_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, pre_req, post_req, dbg, has1;
  logic [15:0] old_r, new_r, alt_r;
  logic bus_rd, bus_wr, busy, done, err, warn, pll_ready;
  logic [3:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  dvfs_clk_seq #(.TIMEOUT_CYC(16)) u_dut (
    .clk(clk), .rst(rst), .pre_req(pre_req), .post_req(post_req),
    .old_rate(old_r), .new_rate(new_r), .alt_rate(alt_r),
    .dbg_div_en(dbg), .has_div1(has1),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .err(err), .warn(warn), .pll_ready(pll_ready));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int last_ix = 0;

  int          t_rate[5] = '{1200, 1000, 800, 500, 0};
  logic [31:0] t_d0[5]   = '{32'h0005_3100, 32'h0004_2100, 32'h0003_2100, 32'h0002_1100, 32'h0};
  logic [31:0] t_d1[5]   = '{32'h53, 32'h43, 32'h33, 32'h23, 32'h0};

  // behavioural register model of the clock control unit
  logic [31:0] m_sel, m_div0, m_div1;
  int p_sel, p_d0, p_d1;
  logic stuck = 1'b0, set_hpm = 1'b0, clr_hpm = 1'b0;

  always_comb begin
    case (bus_addr)
      RA_SEL:    bus_rdata = m_sel;
      RA_SELST:  bus_rdata = {13'b0, (p_sel > 0) ? 3'd4 : (m_sel[16] ? 3'd2 : 3'd1), 16'b0};
      RA_DIV0:   bus_rdata = m_div0;
      RA_DIV0ST: bus_rdata = (p_d0 > 0 || stuck) ? 32'h0007_0007 : 32'h0;
      RA_DIV1:   bus_rdata = m_div1;
      RA_DIV1ST: bus_rdata = (p_d1 > 0) ? 32'h77 : 32'h0;
      default:   bus_rdata = 32'h0;
    endcase
  end

  always @(posedge clk) begin
    if (rst) begin
      m_sel <= 32'h0000_0003; m_div0 <= 32'hA000_0004; m_div1 <= 32'h0000_0166;
      p_sel <= 0; p_d0 <= 0; p_d1 <= 0;
    end else begin
      if (p_sel > 0) p_sel <= p_sel - 1;
      if (p_d0 > 0) p_d0 <= p_d0 - 1;
      if (p_d1 > 0) p_d1 <= p_d1 - 1;
      if (set_hpm) m_sel[20] <= 1'b1;
      if (clr_hpm) m_sel[20] <= 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          RA_SEL:  begin m_sel <= bus_wdata; p_sel <= 3; end
          RA_DIV0: begin m_div0 <= bus_wdata; p_d0 <= 3; end
          RA_DIV1: begin m_div1 <= bus_wdata; p_d1 <= 3; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected write stream, compared on every clock
  logic [35:0] exq[$];
  string       extag[$];

  always @(negedge clk) begin
    if (!rst && bus_wr) begin
      if (exq.size() == 0) chk(0, "R6 unexpected write", {28'h0, bus_addr, bus_wdata}, 0);
      else begin
        logic [35:0] e;
        string tg;
        e = exq.pop_front();
        tg = extag.pop_front();
        chk({bus_addr, bus_wdata} == e, tg, {bus_addr, bus_wdata}, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_fail++;
      $display("FAIL R10 watchdog expired: actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int find_ix(input int n);
    for (int i = 0; i < 5; i++) begin
      if (t_rate[i] == 0) return -1;
      if (t_rate[i] == n) return i;
    end
    return -1;
  endfunction

  task automatic wait_done(input string tag);
    int k = 0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    chk(done, tag, done, 1);
  endtask

  task automatic do_pre(input int o, input int n, input int a, input bit d, input bit h,
                        input bit e_err, input bit e_warn, input bit e_rdy);
    int ix, m, q, sf;
    logic [31:0] msk, sv, d1v;
    ix = find_ix(n);
    sv = 0;
    msk = 32'h7 | (d ? 32'h0007_0000 : 32'h0);
    if (ix >= 0) begin
      if (a > o || o > n) begin
        m = (o < n) ? o : n;
        q = (a + m - 1) / m;
        sf = (q > 0) ? q - 1 : 0;
        sv = (sf & 7) | (d ? 32'h0007_0000 : 32'h0);
        exq.push_back({RA_DIV0, (m_div0 & ~msk) | (sv & msk)}); extag.push_back("R4 protective divider");
      end
      exq.push_back({RA_SEL, m_sel | 32'h0001_0000}); extag.push_back("R6 alt select");
      exq.push_back({RA_DIV0, t_d0[ix] | sv}); extag.push_back("R6 divider 0 load");
      d1v = m_sel[20] ? (m_div1 & 32'h77) : t_d1[ix];
      if (h) begin exq.push_back({RA_DIV1, d1v}); extag.push_back("R7 divider 1 load"); end
      last_ix = ix;
    end
    old_r = 16'(o); new_r = 16'(n); alt_r = 16'(a); dbg = d; has1 = h;
    pre_req = 1'b1;
    @(negedge clk);
    pre_req = 1'b0;
    chk(busy, "R10 busy after pre", busy, 1);
    wait_done("R10 pre done pulse");
    chk(err == e_err, "R9 err after pre", err, e_err);
    chk(warn == e_warn, "R5 warn after pre", warn, e_warn);
    chk(pll_ready == e_rdy, "R6 pll_ready after pre", pll_ready, e_rdy);
    chk(exq.size() == 0, "R2 pending expected writes", exq.size(), 0);
    @(negedge clk);
  endtask

  task automatic do_post(input bit d);
    logic [31:0] msk;
    msk = 32'h7 | (d ? 32'h0007_0000 : 32'h0);
    exq.push_back({RA_SEL, m_sel & ~32'h0001_0000}); extag.push_back("R8 primary select");
    exq.push_back({RA_DIV0, (m_div0 & ~msk) | (d ? (t_d0[last_ix] & 32'h0007_0000) : 32'h0)});
    extag.push_back("R8 divider restore");
    dbg = d;
    post_req = 1'b1;
    @(negedge clk);
    post_req = 1'b0;
    chk(!pll_ready, "R8 pll_ready falls on post", pll_ready, 0);
    wait_done("R10 post done pulse");
    chk(!err, "R10 err cleared on post", err, 0);
    chk(exq.size() == 0, "R8 pending expected writes", exq.size(), 0);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; pre_req = 0; post_req = 0; old_r = 0; new_r = 0; alt_r = 0; dbg = 0; has1 = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, err, warn, pll_ready} == 5'b0, "R1 reset outputs", {busy, done, err, warn, pll_ready}, 0);
    chk(!bus_rd && !bus_wr, "R1 idle bus", {bus_rd, bus_wr}, 0);

    // R3 R4: alternate above old, ratio 1
    do_pre(800, 1200, 1000, 0, 1, 0, 0, 1);
    do_post(0);
    // R4: old above new with debug field, ratio 2
    do_pre(1200, 800, 2000, 1, 1, 0, 0, 1);
    do_post(1);
    // R3 R7: no protective divider, HPM source bit keeps divider 1 fields
    set_hpm = 1'b1; @(negedge clk); set_hpm = 1'b0; @(negedge clk);
    do_pre(800, 1000, 500, 0, 1, 0, 0, 1);
    do_post(0);
    clr_hpm = 1'b1; @(negedge clk); clr_hpm = 1'b0; @(negedge clk);
    // R2: no table match
    do_pre(800, 900, 1000, 0, 1, 1, 0, 0);
    // R5: out of range value, no divider 1
    do_pre(1000, 500, 5000, 0, 0, 0, 1, 1);
    do_post(0);
    // R11: post ignored when not ready
    post_req = 1'b1; @(negedge clk); post_req = 1'b0;
    chk(!busy, "R11 post ignored when not ready", busy, 0);
    // R9: divider status never settles, sequence still completes
    stuck = 1'b1;
    do_pre(800, 1000, 1000, 0, 1, 1, 0, 1);
    stuck = 1'b0;
    // R11: pre ignored while ready
    pre_req = 1'b1; @(negedge clk); pre_req = 1'b0;
    chk(!busy, "R11 pre ignored while ready", busy, 0);
    chk(pll_ready, "R11 ready held", pll_ready, 1);
    do_post(0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule